// File: doc/BRIEF.md
# Multi-Channel Offset PWM Generator

This block drives a parameterised number of PWM lines (one to sixteen) from a single clock. Each lane is set by three 32-bit counts: the period, the length of the high phase and the position where that high phase starts within the period. All counts are in input clock cycles. Software reaches the block through a plain word-addressed register bus with address, write data, write strobe and a combinational read-data return.

Lane parameters are double-buffered. A bus write only updates a shadow copy, and a global commit command moves every shadow copy into the working set at once. When the immediate-commit option is on, the swap happens on the commit write itself. When it is off, the swap waits until each running lane has reached the end of its current period. In both cases every lane counter restarts from zero on the swap, so the lanes come out phase-aligned. A control bit holds the whole generator idle. The block also has an identity word, a fixed signature word, a scratch word and a read-only lane count.

Top module: `phase_pwm_core`

## Requirements
- R1: After rst_n the block reads back as follows: 0x04 returns CORE_ID (default 0x00010200), 0x0C returns 0x601A3471, 0x14 returns NUM_CH, 0x10 returns 1 (idle hold set), 0x18 returns 0, and all lane registers return 0. Addresses not in the map read 0.
- R2: Address 0x08 is a 32-bit scratch word that reads back the last value written to it.
- R3: Lane registers sit at 0x40+4*n (period), 0x80+4*n (high length) and 0xC0+4*n (start offset). A write to one of them changes only its shadow copy, which reads back at once, and leaves every PWM output unchanged until a commit.
- R4: In word 0x10, bit 0 is the idle hold and reads back its stored value. Bit 1 is the commit command: writing it as 1 issues a commit, and it always reads as 0.
- R5: While the idle hold is set, every output is low. When the hold is cleared, every lane counts again from count 0 with its working parameters unchanged.
- R6: Within a period the lane count runs from 0 to period-1. The output is high while offset <= count < offset+length. The high phase is cut off at the end of the period and does not carry into the next one.
- R7: A lane whose working period is 0 is disabled, and its output stays low.
- R8: A lane whose high length is greater than or equal to its period, with its offset below the period, is high for the whole period.
- R9: A lane whose offset is greater than or equal to its period stays low for the whole period, whatever its high length.
- R10: With bit 1 of word 0x18 set (immediate commit), a commit replaces all working parameters on the clock edge of the commit write. All lane counters restart at 0 on that edge.
- R11: With bit 1 of word 0x18 clear, a commit takes effect on the edge that follows the cycle in which the last enabled lane finishes the period it was running when the commit was issued. Until then the old waveforms continue, and afterwards all lanes restart together at count 0.
- R12: Once the idle hold is released after rst_n, all outputs stay low until parameters are written and committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and all lane counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | NUM_CH | One PWM line per lane |

## Verification
The bench checks the truncated high phase at the end of a period, a high length equal to the period with a non-zero offset, an offset equal to the period, and a disabled lane. A wrong comparison order would leak the high phase into the next period or let offset and length override each other. The deferred commit is issued while the lanes sit at unrelated counts. A design that swaps early, swaps late, or waits for lanes that are switched off shows the new waveform on the wrong cycle. The bench also holds the block idle and releases it, which catches counters that are not restarted from zero or working values that are lost during the hold.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;

  localparam logic [ADDR_W-1:0] A_IDENT   = 8'h04;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 8'h08;
  localparam logic [ADDR_W-1:0] A_SIGN    = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h10;
  localparam logic [ADDR_W-1:0] A_LANES   = 8'h14;
  localparam logic [ADDR_W-1:0] A_OPTS    = 8'h18;

  localparam logic [1:0] BANK_PER  = 2'b01;
  localparam logic [1:0] BANK_LEN  = 2'b10;
  localparam logic [1:0] BANK_OFS  = 2'b11;

  localparam logic [DATA_W-1:0] SIGN_WORD = 32'h601A3471;

  typedef struct packed {
    logic [DATA_W-1:0] period;
    logic [DATA_W-1:0] length;
    logic [DATA_W-1:0] offset;
  } lane_cfg_t;

endpackage

// File: rtl/phase_pwm_regs.sv
module phase_pwm_regs
  import phase_pwm_pkg::*;
#(
  parameter int                NUM_CH  = 8,
  parameter logic [DATA_W-1:0] CORE_ID = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output lane_cfg_t         shadow_o [NUM_CH],
  output logic              hold_q,
  output logic              hold_d,
  output logic              force_q,
  output logic              load_pulse
);

  logic              wr_ctrl, wr_opts, wr_scr;
  logic              force_d;
  logic [DATA_W-1:0] scratch_q, scratch_d;
  logic [1:0]        bank;
  logic [IDX_W-1:0]  idx;
  logic              word_ok;

  assign bank    = bus_addr[7:6];
  assign idx     = bus_addr[5:2];
  assign word_ok = (bus_addr[1:0] == 2'b00);

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_opts = bus_we && (bus_addr == A_OPTS);
  assign wr_scr  = bus_we && (bus_addr == A_SCRATCH);

  // next-state for global control
  always_comb begin
    hold_d    = hold_q;
    force_d   = force_q;
    scratch_d = scratch_q;
    if (wr_ctrl) hold_d    = bus_wdata[0];
    if (wr_opts) force_d   = bus_wdata[1];
    if (wr_scr)  scratch_d = bus_wdata;
  end

  assign load_pulse = wr_ctrl && bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b1;
      force_q   <= 1'b0;
      scratch_q <= '0;
    end else begin
      if (wr_ctrl) hold_q    <= hold_d;
      if (wr_opts) force_q   <= force_d;
      if (wr_scr)  scratch_q <= scratch_d;
    end
  end

  // per-lane shadow copies
  for (genvar g = 0; g < NUM_CH; g++) begin : g_shadow
    lane_cfg_t cfg_q, cfg_d;
    logic      hit;

    assign hit = bus_we && word_ok && (idx == IDX_W'(g)) && (bank != 2'b00);

    always_comb begin
      cfg_d = cfg_q;
      case (bank)
        BANK_PER: cfg_d.period = bus_wdata;
        BANK_LEN: cfg_d.length = bus_wdata;
        BANK_OFS: cfg_d.offset = bus_wdata;
        default:  cfg_d = cfg_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg_q <= '0;
      else if (hit) cfg_q <= cfg_d;
    end

    assign shadow_o[g] = cfg_q;
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bank == 2'b00) begin
      case (bus_addr)
        A_IDENT:   bus_rdata = CORE_ID;
        A_SCRATCH: bus_rdata = scratch_q;
        A_SIGN:    bus_rdata = SIGN_WORD;
        A_CTRL:    bus_rdata = {{(DATA_W-1){1'b0}}, hold_q};
        A_LANES:   bus_rdata = DATA_W'(NUM_CH);
        A_OPTS:    bus_rdata = {{(DATA_W-2){1'b0}}, force_q, 1'b0};
        default:   bus_rdata = '0;
      endcase
    end else if (word_ok) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (idx == IDX_W'(c)) begin
          case (bank)
            BANK_PER: bus_rdata = shadow_o[c].period;
            BANK_LEN: bus_rdata = shadow_o[c].length;
            default:  bus_rdata = shadow_o[c].offset;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/phase_pwm_sync.sv
module phase_pwm_sync #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_pulse,
  input  logic              force_q,
  input  logic              hold_q,
  input  logic [NUM_CH-1:0] wrap_i,
  input  logic [NUM_CH-1:0] idle_i,
  output logic              commit_o
);

  logic              pending_q, pending_d;
  logic [NUM_CH-1:0] done_q, done_d;
  logic [NUM_CH-1:0] ready;
  logic              all_ready;
  logic              instant;

  assign ready     = done_q | wrap_i | idle_i;
  assign all_ready = &ready;
  assign instant   = force_q || hold_q;

  always_comb begin
    commit_o  = 1'b0;
    pending_d = pending_q;
    done_d    = done_q;
    if (load_pulse) begin
      commit_o  = instant;
      pending_d = !instant;
      done_d    = '0;
    end else if (pending_q) begin
      commit_o = hold_q || all_ready;
      if (commit_o) begin
        pending_d = 1'b0;
        done_d    = '0;
      end else begin
        done_d = done_q | wrap_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      done_q    <= '0;
    end else begin
      pending_q <= pending_d;
      done_q    <= done_d;
    end
  end

endmodule

// File: rtl/phase_pwm_lane.sv
module phase_pwm_lane
  import phase_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lane_cfg_t         shadow_i,
  input  logic              commit_i,
  input  logic              hold_q,
  input  logic              hold_d,
  output logic              pwm_o,
  output logic              wrap_o,
  output logic              idle_o,
  output logic [DATA_W-1:0] period_o,
  output logic [DATA_W-1:0] cnt_o
);

  lane_cfg_t         act_q, act_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              pwm_q, pwm_d;
  logic              last;

  function automatic logic level(input logic [DATA_W-1:0] c,
                                 input lane_cfg_t         w);
    logic [DATA_W:0] stop;
    stop = {1'b0, w.offset} + {1'b0, w.length};
    if (w.period == '0)            return 1'b0;
    else if (w.offset >= w.period) return 1'b0;
    else if (w.length >= w.period) return 1'b1;
    else return (c >= w.offset) && ({1'b0, c} < stop);
  endfunction

  assign idle_o = (act_q.period == '0);
  assign last   = !idle_o && (cnt_q >= act_q.period - DATA_W'(1));
  assign wrap_o = !hold_q && last;

  always_comb begin
    act_d = commit_i ? shadow_i : act_q;
    if (hold_q || commit_i || idle_o || last) cnt_d = '0;
    else                                      cnt_d = cnt_q + DATA_W'(1);
    pwm_d = hold_d ? 1'b0 : level(cnt_d, act_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (commit_i) act_q <= act_d;
      cnt_q <= cnt_d;
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o    = pwm_q;
  assign period_o = act_q.period;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/phase_pwm_core.sv
module phase_pwm_core
  import phase_pwm_pkg::*;
#(
  parameter int                NUM_CH  = 8,
  parameter logic [DATA_W-1:0] CORE_ID = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_o
);

  localparam int FLAT_W = NUM_CH * DATA_W;

  lane_cfg_t         shadow [NUM_CH];
  logic              hold_q, hold_d, force_q, load_pulse, commit;
  logic [NUM_CH-1:0] wrap, idle;
  logic [FLAT_W-1:0] act_per_flat, cnt_flat;

  phase_pwm_regs #(.NUM_CH(NUM_CH), .CORE_ID(CORE_ID)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .shadow_o   (shadow),
    .hold_q     (hold_q),
    .hold_d     (hold_d),
    .force_q    (force_q),
    .load_pulse (load_pulse)
  );

  phase_pwm_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_pulse (load_pulse),
    .force_q    (force_q),
    .hold_q     (hold_q),
    .wrap_i     (wrap),
    .idle_i     (idle),
    .commit_o   (commit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    phase_pwm_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .shadow_i (shadow[g]),
      .commit_i (commit),
      .hold_q   (hold_q),
      .hold_d   (hold_d),
      .pwm_o    (pwm_o[g]),
      .wrap_o   (wrap[g]),
      .idle_o   (idle[g]),
      .period_o (act_per_flat[g*DATA_W +: DATA_W]),
      .cnt_o    (cnt_flat[g*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/phase_pwm_checker.sv
module phase_pwm_checker
  import phase_pwm_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [7:0]               bus_addr,
  input logic [31:0]              bus_rdata,
  input logic [NUM_CH-1:0]        pwm_o,
  input logic                     hold_q,
  input logic                     force_q,
  input logic                     load_pulse,
  input logic                     commit,
  input logic [NUM_CH*DATA_W-1:0] act_per_flat,
  input logic [NUM_CH*DATA_W-1:0] cnt_flat
);

  p_sign_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_SIGN) |-> (bus_rdata == SIGN_WORD));

  p_commit_bit_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[1] == 1'b0));

  p_shadow_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_per_flat));

  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (pwm_o == '0));

  p_instant_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && force_q) |-> commit);

  p_realign_r11: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt_flat == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane_chk
    p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_per_flat[g*DATA_W +: DATA_W] == '0) |-> !pwm_o[g]);
  end

endmodule

bind phase_pwm_core phase_pwm_checker #(.NUM_CH(NUM_CH)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .pwm_o        (pwm_o),
  .hold_q       (hold_q),
  .force_q      (force_q),
  .load_pulse   (load_pulse),
  .commit       (commit),
  .act_per_flat (act_per_flat),
  .cnt_flat     (cnt_flat)
);

// File: tb/tb_phase_pwm_core.sv
module tb_phase_pwm_core;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic           bus_we = 1'b0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] pwm_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned cyc = 0;

  typedef struct {
    int unsigned    at;
    logic [NCH-1:0] vec;
    string          tag;
  } exp_t;
  exp_t sb[$];

  // reference state: shadow, working set, edge at which count 0 began
  int unsigned sP[NCH], sD[NCH], sO[NCH];
  int unsigned aP[NCH], aD[NCH], aO[NCH], base[NCH];
  logic        holding = 1'b0;

  phase_pwm_core #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic lvl(int unsigned c, int unsigned p, int unsigned d, int unsigned o);
    if (p == 0) return 1'b0;
    if (o >= p) return 1'b0;
    if (d >= p) return 1'b1;
    return (c >= o) && (longint'(c) < longint'(o) + longint'(d));
  endfunction

  function automatic logic [NCH-1:0] exp_vec(int unsigned m);
    logic [NCH-1:0] v = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (!holding && aP[ch] != 0)
        v[ch] = lvl((m - base[ch]) % aP[ch], aP[ch], aD[ch], aO[ch]);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compare each queued expectation in its cycle
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].at == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pwm_o !== e.vec) begin
        errors++;
        $display("FAIL %s: cycle %0d pwm %b expected %b", e.tag, cyc, pwm_o, e.vec);
      end
    end
  end

  task automatic push_run(int unsigned first, int unsigned n, string tag);
    for (int unsigned m = first; m < first + n; m++) begin
      exp_t e;
      e.at = m; e.vec = exp_vec(m); e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_lane(int ch, int unsigned p, int unsigned d, int unsigned o);
    bus_write(8'h40 + 8'(4*ch), p);
    bus_write(8'h80 + 8'(4*ch), d);
    bus_write(8'hC0 + 8'(4*ch), o);
    sP[ch] = p; sD[ch] = d; sO[ch] = o;
  endtask

  task automatic take_shadow(int unsigned edge_no);
    for (int ch = 0; ch < NCH; ch++) begin
      aP[ch] = sP[ch]; aD[ch] = sD[ch]; aO[ch] = sO[ch]; base[ch] = edge_no;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int unsigned e_no, kl, kc;
    for (int ch = 0; ch < NCH; ch++) begin
      sP[ch] = 0; sD[ch] = 0; sO[ch] = 0;
      aP[ch] = 0; aD[ch] = 0; aO[ch] = 0; base[ch] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 pwm after reset", 32'(pwm_o), 0);
    bus_read(8'h04, rd); chk("R1 ident", rd, 32'h0001_0200);
    bus_read(8'h0C, rd); chk("R1 signature", rd, 32'h601A3471);
    bus_read(8'h14, rd); chk("R1 lane count", rd, NCH);
    bus_read(8'h10, rd); chk("R1 control holds", rd, 1);
    bus_read(8'h18, rd); chk("R1 options", rd, 0);
    bus_read(8'h44, rd); chk("R1 lane1 period", rd, 0);
    bus_read(8'h00, rd); chk("R1 unmapped", rd, 0);

    // R2: scratch
    bus_write(8'h08, 32'hA5A5_5A5A);
    bus_read(8'h08, rd); chk("R2 scratch", rd, 32'hA5A5_5A5A);

    // R12: release hold, outputs stay low
    bus_write(8'h10, 32'h0);
    push_run(cyc, 10, "R12 quiet after release");
    drain();

    // R3: shadow writes invisible until commit
    set_lane(0, 10, 3, 2);
    push_run(cyc, 12, "R3 shadow has no effect");
    bus_read(8'h40, rd); chk("R3 period readback", rd, 10);
    bus_read(8'hC0, rd); chk("R3 offset readback", rd, 2);
    drain();

    // R10/R6: immediate commit
    bus_write(8'h18, 32'h2);
    bus_read(8'h18, rd); chk("R10 options readback", rd, 2);
    bus_write(8'h10, 32'h2);
    e_no = cyc; take_shadow(e_no);
    push_run(e_no, 25, "R6 R10 window");
    drain();
    bus_read(8'h10, rd); chk("R4 commit bit self clears", rd, 0);

    // R7 R8 R9 R6 R10: mixed lanes
    set_lane(0, 0, 4, 0);
    set_lane(1, 8, 8, 3);
    set_lane(2, 6, 2, 6);
    set_lane(3, 7, 5, 4);
    bus_write(8'h10, 32'h2);
    e_no = cyc; take_shadow(e_no);
    push_run(e_no, 30, "R6 R7 R8 R9 R10 mixed lanes");
    drain();

    // R11: deferred commit
    bus_write(8'h18, 32'h0);
    set_lane(0, 5, 2, 1);
    set_lane(1, 8, 4, 0);
    set_lane(2, 6, 3, 2);
    repeat (3) @(negedge clk);
    bus_write(8'h10, 32'h2);
    kl = cyc;
    kc = kl + 1;
    for (int ch = 0; ch < NCH; ch++) begin
      if (aP[ch] != 0) begin
        int unsigned j;
        j = kl + (aP[ch] - 1 - ((kl - base[ch]) % aP[ch]));
        if (j + 1 > kc) kc = j + 1;
      end
    end
    push_run(kl, kc - kl, "R11 old waveform before swap");
    take_shadow(kc);
    push_run(kc, 30, "R11 aligned after swap");
    drain();

    // R5: hold and release
    bus_write(8'h10, 32'h1);
    holding = 1'b1;
    push_run(cyc, 10, "R5 held low");
    drain();
    bus_read(8'h10, rd); chk("R4 hold readback", rd, 1);
    bus_write(8'h10, 32'h0);
    holding = 1'b0;
    e_no = cyc;
    for (int ch = 0; ch < NCH; ch++) base[ch] = e_no;
    push_run(e_no, 20, "R5 restart from zero");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule